// File: doc/BRIEF.md
# Closed-Loop Supply Cascade Sequencer

This block brings up a chain of supplies in a fixed order. It has one active-low power-up enable for each supply after the first. An enable is released only under two conditions. First, the supply ahead of it in the chain must be reported good by its digital "above threshold" flag. Second, a programmed delay must then have run out. The delay timer for a stage starts only after the preceding supply is confirmed good. A slow supply therefore stretches the sequence rather than being overtaken by it.

The first supply is the primary one, and nothing happens until it is good. A reset-active input takes the shared delay timer away from the sequencer for as long as it is high. While it is high the sequence pauses without losing the stages already completed. A disable input freezes the sequence entirely. Delays are counted in millisecond ticks; the tick count for one unit is a parameter. The busy output shows when the sequencer holds the shared timer.

Top module: `supply_cascade_seq`

## Requirements
- R1: While `seq_off` is 1 the sequence makes no progress: `pwr_en_n` does not change and `tmr_busy` is 0. When `seq_off` returns to 0 with the awaited flag already good, the pending stage's enable falls at edge N+2+T, where N is the edge count when `seq_off` was cleared.
- R2: No enable falls and the timer stays idle while `supp_ok[0]` is low, even if later supplies are good.
- R3: Enables fall strictly in index order. `pwr_en_n[k]` is never 0 unless `pwr_en_n[k-1]` is 0.
- R4: `supp_ok` passes through a two-flop synchronizer. If the awaited flag rises while its stage waits, the enable falls at edge N+4+T, where N is the last edge before the change. If the flag is already good when the previous enable falls at edge P, the next enable falls at edge P+2+T. An enable falls only in a cycle after the timer was busy.
- R5: The delay code of stage k sits in `dly_codes[2k+1:2k]`. The codes 00, 01, 10 and 11 give T = 0, 1, 2 and 4 units of `DLY_UNIT` ticks respectively.
- R6: While `rst_hold` is 1 the stage in progress is paused, `tmr_busy` is 0 from the next edge, and enables already asserted stay asserted. The paused stage then reruns its full delay: its enable falls at edge R+2+T, where R is the edge count when `rst_hold` was cleared.
- R7: `tmr_busy` is 1 exactly while a stage delay is being counted.
- R8: An asserted enable stays asserted even if its supply is lost. A 1 on `seq_clr` releases all enables at the next edge.
- R9: After power-on reset all enables read 1 and `tmr_busy` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| seq_clr | input | 1 | Synchronous clear of the whole sequence |
| supp_ok | input | STAGES | Per-supply above-threshold flags, asynchronous |
| seq_off | input | 1 | 1 disables cascading |
| dly_codes | input | 2*STAGES | 2-bit delay code per stage |
| rst_hold | input | 1 | Reset time-out owns the shared timer |
| tick_ms | input | 1 | One-cycle millisecond tick |
| pwr_en_n | output | STAGES | Active-low power-up enables |
| tmr_busy | output | 1 | Sequencer is using the shared timer |

## Verification
The bench targets the mixed-delay pattern 10/00/10, which would expose swapped code fields or a delay measured from the wrong event. It checks early-arriving later supplies: a design that does not gate everything on the primary supply would release enables out of order. A reset pulse is applied in the middle of a delay. A design that restarted from stage zero would drop an earlier enable, and one that kept counting would release the enable too soon. Finally, supplies are removed after completion to show the enables do not roll back, and the disable bit is checked to show it freezes the sequence.

// File: rtl/cas_pkg.sv
package cas_pkg;
  // Delay code to tick count: 00 none, 01 one unit, 10 two, 11 four.
  function automatic int unsigned code_to_ticks(input logic [1:0] code,
                                                input int unsigned unit);
    case (code)
      2'b00:   return 0;
      2'b01:   return unit;
      2'b10:   return 2 * unit;
      default: return 4 * unit;
    endcase
  endfunction
endpackage

// File: rtl/cas_sync.sv
module cas_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta[g]   <= 1'b0;
        q_sync[g] <= 1'b0;
      end else begin
        meta[g]   <= d_async[g];
        q_sync[g] <= meta[g];
      end
    end
  end
endmodule

// File: rtl/cas_timer.sv
module cas_timer #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] target,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = run && (cnt >= target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run)           cnt <= '0;
    else if (tick && !done)  cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/cas_stage_fsm.sv
module cas_stage_fsm #(
  parameter int STAGES = 3,
  localparam int IDXW  = $clog2(STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              pause,
  input  logic [STAGES-1:0] vld,
  input  logic              tmr_done,
  output logic [IDXW-1:0]   stg,
  output logic              run,
  output logic              fire,
  output logic [STAGES-1:0] granted
);
  logic all_done, cur_vld, start;

  assign all_done = (stg == IDXW'(STAGES));

  always_comb begin
    cur_vld = 1'b0;
    for (int i = 0; i < STAGES; i++)
      if (stg == IDXW'(i)) cur_vld = vld[i];
  end

  assign start = !pause && !run && !all_done && cur_vld;
  assign fire  = !pause && run && tmr_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
      run <= 1'b0;
    end else if (clr) begin
      stg <= '0;
      run <= 1'b0;
    end else if (pause) begin
      run <= 1'b0;
    end else if (start) begin
      run <= 1'b1;
    end else if (fire) begin
      stg <= stg + IDXW'(1);
      run <= 1'b0;
    end
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_grant
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           granted[g] <= 1'b0;
      else if (clr)                         granted[g] <= 1'b0;
      else if (fire && stg == IDXW'(g))     granted[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/supply_cascade_seq.sv
module supply_cascade_seq #(
  parameter int STAGES   = 3,
  parameter int DLY_UNIT = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                seq_clr,
  input  logic [STAGES-1:0]   supp_ok,
  input  logic                seq_off,
  input  logic [2*STAGES-1:0] dly_codes,
  input  logic                rst_hold,
  input  logic                tick_ms,
  output logic [STAGES-1:0]   pwr_en_n,
  output logic                tmr_busy
);
  localparam int CW   = $clog2(4 * DLY_UNIT + 1);
  localparam int IDXW = $clog2(STAGES + 1);

  logic [STAGES-1:0] ok_s;
  logic [STAGES-1:0] granted;
  logic [IDXW-1:0]   stg;
  logic [CW-1:0]     tgt [STAGES];
  logic [CW-1:0]     cur_tgt;
  logic              run, tmr_done, stg_fire, pause;

  assign pause = seq_off || rst_hold;

  cas_sync #(.W(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(supp_ok), .q_sync(ok_s)
  );

  for (genvar g = 0; g < STAGES; g++) begin : g_tgt
    assign tgt[g] = CW'(cas_pkg::code_to_ticks(dly_codes[2*g +: 2], DLY_UNIT));
  end

  always_comb begin
    cur_tgt = '0;
    for (int i = 0; i < STAGES; i++)
      if (stg == IDXW'(i)) cur_tgt = tgt[i];
  end

  cas_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick_ms),
    .target(cur_tgt), .done(tmr_done)
  );

  cas_stage_fsm #(.STAGES(STAGES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .clr(seq_clr), .pause(pause), .vld(ok_s),
    .tmr_done(tmr_done), .stg(stg), .run(run), .fire(stg_fire),
    .granted(granted)
  );

  assign pwr_en_n = ~granted;
  assign tmr_busy = run;
endmodule

// File: rtl/supply_cascade_seq_chk.sv
module supply_cascade_seq_chk #(
  parameter int STAGES = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seq_clr,
  input logic              seq_off,
  input logic              rst_hold,
  input logic [STAGES-1:0] pwr_en_n,
  input logic              tmr_busy,
  input logic              stg_fire
);
  assert_freeze_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_off && !seq_clr) |=> $stable(pwr_en_n));

  assert_pause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hold |=> !tmr_busy);

  assert_fire_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stg_fire |-> tmr_busy);

  for (genvar g = 0; g < STAGES; g++) begin : g_bit
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_en_n[g] && !seq_clr) |=> !pwr_en_n[g]);

    assert_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_en_n[g]) |-> $past(tmr_busy));

    if (g > 0) begin : g_ord
      assert_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en_n[g] |-> !pwr_en_n[g-1]);
    end
  end
endmodule

bind supply_cascade_seq supply_cascade_seq_chk #(.STAGES(STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .seq_clr(seq_clr), .seq_off(seq_off),
  .rst_hold(rst_hold), .pwr_en_n(pwr_en_n), .tmr_busy(tmr_busy),
  .stg_fire(stg_fire)
);

// File: tb/supply_cascade_seq_bench.sv
module supply_cascade_seq_bench;
  localparam int U  = 4;
  localparam int ST = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          seq_clr = 1'b0;
  logic [ST-1:0] supp_ok = '0;
  logic          seq_off = 1'b0;
  logic [5:0]    dly_codes = '0;
  logic          rst_hold = 1'b0;
  logic          tick_ms = 1'b1;
  logic [ST-1:0] pwr_en_n;
  logic          tmr_busy;

  supply_cascade_seq #(.STAGES(ST), .DLY_UNIT(U)) u_supply_cascade_seq (
    .clk(clk), .rst_n(rst_n), .seq_clr(seq_clr), .supp_ok(supp_ok),
    .seq_off(seq_off), .dly_codes(dly_codes), .rst_hold(rst_hold),
    .tick_ms(tick_ms), .pwr_en_n(pwr_en_n), .tmr_busy(tmr_busy)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  typedef struct { int idx; int at; string req; } exp_t;
  exp_t q[$];

  function automatic int ticks(input logic [1:0] c);
    if (c == 2'b00) return 0;
    if (c == 2'b01) return U;
    if (c == 2'b10) return 2 * U;
    return 4 * U;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_en(input int idx, input int at, input string req);
    exp_t e;
    e.idx = idx; e.at = at; e.req = req;
    q.push_back(e);
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 300 && q.size() != 0; i++) @(negedge clk);
    chk(q.size() == 0, req, "pending enables", q.size(), 0);
    q.delete();
  endtask

  task automatic restart();
    supp_ok = '0; seq_off = 1'b0; rst_hold = 1'b0;
    step(3);
    seq_clr = 1'b1;
    step(1);
    seq_clr = 1'b0;
    chk(pwr_en_n == 3'b111, "R8", "clear releases", pwr_en_n, 3'b111);
    step(1);
  endtask

  // Monitor: every falling enable must match the head of the queue.
  logic [ST-1:0] prev = 3'b111;
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < ST; i++) begin
        if (prev[i] && !pwr_en_n[i]) begin
          if (q.size() == 0) begin
            chk(1'b0, "R3", "unexpected enable", i, -1);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk(e.idx == i, e.req, "enable index", i, e.idx);
            chk(e.at == cyc, e.req, "enable edge", cyc, e.at);
          end
        end
      end
      prev = pwr_en_n;
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    summary();
  end

  initial begin
    int n, p;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk(pwr_en_n == 3'b111, "R9", "reset enables", pwr_en_n, 3'b111);
    chk(tmr_busy == 1'b0, "R9", "reset busy", tmr_busy, 0);

    // R5/R4: mixed codes 10,00,10, each supply raised after the previous enable
    dly_codes = 6'b10_00_10;
    n = cyc; supp_ok[0] = 1'b1;
    expect_en(0, n + 4 + ticks(2'b10), "R4");
    step(5);
    chk(tmr_busy == 1'b1, "R7", "busy while counting", tmr_busy, 1);
    drain("R4");
    chk(tmr_busy == 1'b0, "R7", "idle after enable", tmr_busy, 0);
    n = cyc; supp_ok[1] = 1'b1;
    expect_en(1, n + 4 + ticks(2'b00), "R5");
    drain("R5");
    n = cyc; supp_ok[2] = 1'b1;
    expect_en(2, n + 4 + ticks(2'b10), "R5");
    drain("R5");
    chk(pwr_en_n == 3'b000, "R3", "all enabled", pwr_en_n, 0);
    supp_ok = '0;
    step(10);
    chk(pwr_en_n == 3'b000, "R8", "sticky after loss", pwr_en_n, 0);
    restart();

    // R2: later supplies first, primary last
    dly_codes = 6'b01_11_01;
    supp_ok = 3'b110;
    step(30);
    chk(pwr_en_n == 3'b111, "R2", "no start without primary", pwr_en_n, 3'b111);
    chk(tmr_busy == 1'b0, "R2", "timer idle", tmr_busy, 0);
    n = cyc; supp_ok[0] = 1'b1;
    p = n + 4 + ticks(2'b01);
    expect_en(0, p, "R2");
    p = p + 2 + ticks(2'b11);
    expect_en(1, p, "R4");
    p = p + 2 + ticks(2'b01);
    expect_en(2, p, "R4");
    drain("R2");
    restart();

    // R1: disable freezes, release resumes
    dly_codes = 6'b01_01_01;
    seq_off = 1'b1;
    supp_ok = 3'b111;
    step(20);
    chk(pwr_en_n == 3'b111, "R1", "frozen enables", pwr_en_n, 3'b111);
    chk(tmr_busy == 1'b0, "R1", "frozen timer", tmr_busy, 0);
    n = cyc; seq_off = 1'b0;
    p = n + 2 + U;        expect_en(0, p, "R1");
    p = p + 2 + U;        expect_en(1, p, "R1");
    p = p + 2 + U;        expect_en(2, p, "R1");
    drain("R1");
    restart();

    // R6: reset pause in stage 0 and in stage 1
    dly_codes = 6'b11_11_11;
    supp_ok[0] = 1'b1;
    step(8);
    rst_hold = 1'b1;
    step(1);
    chk(tmr_busy == 1'b0, "R6", "timer yielded", tmr_busy, 0);
    step(9);
    chk(pwr_en_n == 3'b111, "R6", "held during reset", pwr_en_n, 3'b111);
    n = cyc; rst_hold = 1'b0;
    expect_en(0, n + 2 + 4 * U, "R6");
    drain("R6");
    supp_ok[1] = 1'b1;
    step(6);
    rst_hold = 1'b1;
    step(5);
    chk(pwr_en_n == 3'b110, "R6", "stage kept", pwr_en_n, 3'b110);
    n = cyc; rst_hold = 1'b0;
    expect_en(1, n + 2 + 4 * U, "R6");
    drain("R6");
    restart();

    // R5: all zero delays
    dly_codes = 6'b00_00_00;
    n = cyc; supp_ok = 3'b111;
    expect_en(0, n + 4, "R5");
    expect_en(1, n + 6, "R5");
    expect_en(2, n + 8, "R5");
    drain("R5");
    restart();

    // R5: field position of the last stage
    dly_codes = 6'b11_00_00;
    n = cyc; supp_ok = 3'b111;
    expect_en(0, n + 4, "R5");
    expect_en(1, n + 6, "R5");
    expect_en(2, n + 8 + 4 * U, "R5");
    drain("R5");

    summary();
  end
endmodule